// File: doc/BRIEF.md
# Flash Embedded-Algorithm Status Flag Generator

This block produces the byte a parallel flash array returns while it runs an internal program or erase. A command decoder, which is not part of the block, issues a single-cycle start pulse with the operation kind, target address and data. It sends this pulse only after the last write of its command sequence. An external operation timer then reports completion or failure. While an operation is busy, a read aimed at an affected sector returns a status byte instead of array contents. The status byte carries a polling bit, a toggling bit, a sticky error bit and an erase-accumulation window bit. Once the operation ends, reads return the stored array byte.

The array is a small behavioural register file. It resets to the erased value 0xFF. Programming can only clear bits. An erase sets every byte of the chosen sectors back to 0xFF. A per-sector protect mask blocks changes. All microsecond durations are replaced by parameterised cycle counts: `ERASE_WIN_CYC` sets the erase accumulation window and `PROT_BUSY_CYC` sets the short busy pulse after an erase whose sectors are all protected.

The read path behaves as a valid-only stream. `rd_req` is sampled on a clock edge, and the response appears with `rd_valid` high for one cycle after that edge. There is no back-pressure: the consumer must take every response in the cycle it is offered, and one request may be issued every cycle.

Top module: `flash_status_gen`

## Requirements
- R1: While a byte program is busy, a status read returns bit 7 equal to the inverse of bit 7 of the data being programmed. After `tmr_done`, reads return the stored byte, which is the old byte ANDed with the programmed data.
- R2: While an erase is busy, a status read returns bit 7 = 0. After completion, every byte of each erased sector reads 0xFF.
- R3: Bit 6 of the status byte reads 0 on the first status read after an operation starts and inverts on each later status read. After completion, two consecutive reads of the same address return identical data.
- R4: Status bytes are returned only after a start pulse has been accepted, and only for reads whose sector (address bits [ADDR_W-1 -: SECT_W]) is a target of the busy operation. Other reads return array data. Status bits 4, 2, 1 and 0 always read 0.
- R5: A program start aimed at a protected sector (`prot_mask` bit set for that sector) is ignored: no status byte is shown and the array is unchanged.
- R6: An erase start (`op_kind` 1 = sector erase, 2 = bulk erase) whose selected sectors are all protected shows the status byte (bit 7 = 0, bit 6 toggling) for `PROT_BUSY_CYC` cycles. Array data then returns, and nothing has been erased.
- R7: A program whose data would turn any stored 0 into a 1 sets bit 5 at once. The operation then stays busy and ignores `tmr_done` until `flash_reset`, and the array byte is not changed.
- R8: `tmr_fail` during a busy operation sets bit 5. Bit 5 stays set until `flash_reset`, which clears bit 5, ends the busy state and resets the toggle bit.
- R9: Bit 3 reads 0 for `ERASE_WIN_CYC` cycles after an accepted sector erase and reads 1 otherwise. A further unprotected sector erase inside the window adds its sector and restarts the window. `tmr_done` is ignored while the window is open.
- R10: A bulk erase (`op_kind` = 2) erases only the unprotected sectors. A start pulse that arrives while busy is ignored unless it is an allowed sector-erase addition.
- R11: Synchronous active-high `rst` sets every array byte to 0xFF and clears the busy, error, window and toggle state. `rd_valid` reads 0 after reset.
- R12: `rd_valid` is high exactly one cycle after each cycle in which `rd_req` is high, and `rd_data` is valid in that cycle. Op kind 0 is byte program. Op kind 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | Single-cycle start of a decoded operation |
| op_kind | input | 2 | 0 program, 1 sector erase, 2 bulk erase |
| op_addr | input | ADDR_W | Target byte address (its sector for erase) |
| op_data | input | 8 | Byte to program |
| prot_mask | input | 2**SECT_W | Per-sector protect bits |
| tmr_done | input | 1 | Operation timer completion |
| tmr_fail | input | 1 | Operation timer time-out failure |
| flash_reset | input | 1 | Reset-flash command: clears error and aborts |
| rd_req | input | 1 | Read request (valid) |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 8 | Array byte or status byte |

## Verification
On every cycle, the embedded assertions check several properties. A protected program never makes the block busy, and an error holds both itself and the busy state until reset-flash. `tmr_done` cannot end an operation while the window is open, and the protect pulse never overlaps a real operation. Programming only ever clears array bits, each status read returns the toggle value from before that read, and every request gets a response on the next cycle. Only the bench's scenarios can show the full byte values across an operation's life: the inverted polling bit against the programmed data, the toggle sequence, window restart and expiry, bulk erase skipping protected sectors, and the array contents after abort and completion.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_SERASE = 2'd1,
    OP_BERASE = 2'd2,
    OP_NONE   = 2'd3
  } op_e;

  localparam int BIT_POLL = 7;
  localparam int BIT_TOG  = 6;
  localparam int BIT_ERR  = 5;
  localparam int BIT_WIN  = 3;
endpackage

// File: rtl/fsg_array.sv
module fsg_array #(
  parameter int ADDR_W = 6,
  parameter int SECT_W = 2,
  localparam int NSECT = 1 << SECT_W,
  localparam int NBYTES = 1 << ADDR_W,
  localparam int PER_SECT = NBYTES / NSECT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_prog,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [7:0]        prog_data,
  input  logic              commit_erase,
  input  logic [NSECT-1:0]  erase_mask,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic [7:0]        rd_byte,
  output logic [7:0]        cur_byte
);
  logic [7:0] mem [NBYTES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBYTES; i++) mem[i] <= 8'hFF;
    end else if (commit_prog) begin
      mem[prog_addr] <= mem[prog_addr] & prog_data;
    end else if (commit_erase) begin
      for (int i = 0; i < NBYTES; i++)
        if (erase_mask[i / PER_SECT]) mem[i] <= 8'hFF;
    end
  end

  assign rd_byte  = mem[rd_addr];
  assign cur_byte = mem[cur_addr];

  // R7: programming may only clear bits
  a_r7_prog_only_clears: assert property (@(posedge clk) disable iff (rst)
    commit_prog |=> ((mem[$past(prog_addr)] & ~$past(mem[prog_addr])) == 8'h00));
endmodule

// File: rtl/fsg_seq.sv
module fsg_seq
  import fsg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SECT_W = 2,
  parameter int ERASE_WIN_CYC = 30,
  parameter int PROT_BUSY_CYC = 25,
  localparam int NSECT = 1 << SECT_W,
  localparam int WIN_W = $clog2(ERASE_WIN_CYC + 1),
  localparam int PP_W = $clog2(PROT_BUSY_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_start,
  input  op_e               op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [7:0]        op_data,
  input  logic [NSECT-1:0]  prot_mask,
  input  logic              tmr_done,
  input  logic              tmr_fail,
  input  logic              flash_reset,
  input  logic [7:0]        cur_byte,
  output logic              op_begin,
  output logic [NSECT-1:0]  hit_mask,
  output logic              poll_bit,
  output logic              err,
  output logic              win_open,
  output logic              commit_prog,
  output logic              commit_erase,
  output logic [NSECT-1:0]  erase_mask,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data
);
  logic              busy_q, err_q;
  op_e               kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [NSECT-1:0]  smask_q;
  logic [WIN_W-1:0]  win_cnt;
  logic [PP_W-1:0]   pp_cnt;

  logic [SECT_W-1:0] sel_sect;
  logic [NSECT-1:0]  req_mask, live_mask;
  logic pp_active, idle, is_erase, start_prog, start_erase, start_pp, add_erase;
  logic zero_to_one, finish;

  assign sel_sect  = op_addr[ADDR_W-1 -: SECT_W];
  assign is_erase  = (op_kind == OP_SERASE) || (op_kind == OP_BERASE);
  assign req_mask  = (op_kind == OP_BERASE) ? {NSECT{1'b1}} : (NSECT'(1) << sel_sect);
  assign live_mask = req_mask & ~prot_mask;
  assign pp_active = (pp_cnt != '0);
  assign win_open  = (win_cnt != '0);
  assign idle      = !busy_q && !pp_active;

  assign start_prog  = op_start && idle && (op_kind == OP_PROG) && (live_mask != '0);
  assign start_erase = op_start && idle && is_erase && (live_mask != '0);
  assign start_pp    = op_start && idle && is_erase && (live_mask == '0);
  assign add_erase   = op_start && busy_q && !err_q && (kind_q == OP_SERASE) && win_open
                       && (op_kind == OP_SERASE) && (live_mask != '0);

  assign zero_to_one = |(op_data & ~cur_byte);
  assign finish      = busy_q && tmr_done && !err_q && !win_open;

  always_ff @(posedge clk) begin
    if (rst || flash_reset) begin
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      win_cnt <= '0;
      pp_cnt  <= '0;
      smask_q <= '0;
      kind_q  <= OP_NONE;
      addr_q  <= '0;
      data_q  <= 8'hFF;
    end else if (start_prog) begin
      busy_q  <= 1'b1;
      kind_q  <= OP_PROG;
      addr_q  <= op_addr;
      data_q  <= op_data;
      smask_q <= live_mask;
      err_q   <= zero_to_one;
    end else if (start_erase) begin
      busy_q  <= 1'b1;
      kind_q  <= op_kind;
      smask_q <= live_mask;
      err_q   <= 1'b0;
      win_cnt <= (op_kind == OP_SERASE) ? WIN_W'(ERASE_WIN_CYC) : '0;
    end else if (start_pp) begin
      pp_cnt  <= PP_W'(PROT_BUSY_CYC);
      kind_q  <= op_kind;
      smask_q <= req_mask;
    end else if (add_erase) begin
      smask_q <= smask_q | live_mask;
      win_cnt <= WIN_W'(ERASE_WIN_CYC);
    end else begin
      if (finish) busy_q <= 1'b0;
      else if (busy_q && tmr_fail) err_q <= 1'b1;
      if (win_open) win_cnt <= win_cnt - 1'b1;
      if (pp_active) pp_cnt <= pp_cnt - 1'b1;
    end
  end

  assign op_begin     = start_prog || start_erase || start_pp;
  assign hit_mask     = (busy_q || pp_active) ? smask_q : '0;
  assign poll_bit     = (kind_q == OP_PROG) ? ~data_q[7] : 1'b0;
  assign err          = err_q;
  assign commit_prog  = finish && (kind_q == OP_PROG);
  assign commit_erase = finish && (kind_q != OP_PROG);
  assign erase_mask   = smask_q;
  assign prog_addr    = addr_q;
  assign prog_data    = data_q;

  // R5: protected program leaves the block idle
  a_r5_prot_prog_ignored: assert property (@(posedge clk) disable iff (rst)
    (op_start && idle && !flash_reset && op_kind == OP_PROG && prot_mask[sel_sect])
      |=> (!busy_q && !pp_active));
  // R8: error is sticky until reset-flash
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_q && !flash_reset) |=> err_q);
  // R7: an error keeps the operation busy
  a_r7_err_holds_busy: assert property (@(posedge clk) disable iff (rst)
    (err_q && !flash_reset) |=> busy_q);
  // R9: completion is ignored inside the erase window
  a_r9_no_finish_in_window: assert property (@(posedge clk) disable iff (rst)
    (busy_q && win_open && !flash_reset) |=> busy_q);
  // R6: the protect pulse never overlaps a real operation
  a_r6_pulse_exclusive: assert property (@(posedge clk) disable iff (rst)
    pp_active |-> !busy_q);
endmodule

// File: rtl/fsg_rdmux.sv
module fsg_rdmux
  import fsg_pkg::*;
#(
  parameter int SECT_W = 2,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flash_reset,
  input  logic              op_begin,
  input  logic              rd_req,
  input  logic [SECT_W-1:0] rd_sect,
  input  logic [7:0]        rd_byte,
  input  logic [NSECT-1:0]  hit_mask,
  input  logic              poll_bit,
  input  logic              err,
  input  logic              win_open,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);
  logic       tog;
  logic       hit;
  logic [7:0] status;

  assign hit = hit_mask[rd_sect];

  always_comb begin
    status           = 8'h00;
    status[BIT_POLL] = poll_bit;
    status[BIT_TOG]  = tog;
    status[BIT_ERR]  = err;
    status[BIT_WIN]  = ~win_open;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
      tog      <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= hit ? status : rd_byte;
      if (op_begin || flash_reset) tog <= 1'b0;
      else if (rd_req && hit) tog <= ~tog;
    end
  end

  // R3: each status read returns the toggle value from before that read
  a_r3_toggle_flips: assert property (@(posedge clk) disable iff (rst)
    (rd_req && hit && !op_begin && !flash_reset) |=> (rd_data[BIT_TOG] != tog));
  // R12: one response per request, on the next cycle
  a_r12_valid_follows: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import fsg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SECT_W = 2,
  parameter int ERASE_WIN_CYC = 30,
  parameter int PROT_BUSY_CYC = 25,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_start,
  input  logic [1:0]        op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [7:0]        op_data,
  input  logic [NSECT-1:0]  prot_mask,
  input  logic              tmr_done,
  input  logic              tmr_fail,
  input  logic              flash_reset,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);
  logic              op_begin, poll_bit, err, win_open, commit_prog, commit_erase;
  logic [NSECT-1:0]  hit_mask, erase_mask;
  logic [ADDR_W-1:0] prog_addr;
  logic [7:0]        prog_data, rd_byte, cur_byte;

  fsg_seq #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W),
    .ERASE_WIN_CYC(ERASE_WIN_CYC), .PROT_BUSY_CYC(PROT_BUSY_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .op_start(op_start), .op_kind(op_e'(op_kind)),
    .op_addr(op_addr), .op_data(op_data), .prot_mask(prot_mask),
    .tmr_done(tmr_done), .tmr_fail(tmr_fail), .flash_reset(flash_reset),
    .cur_byte(cur_byte), .op_begin(op_begin), .hit_mask(hit_mask),
    .poll_bit(poll_bit), .err(err), .win_open(win_open),
    .commit_prog(commit_prog), .commit_erase(commit_erase),
    .erase_mask(erase_mask), .prog_addr(prog_addr), .prog_data(prog_data)
  );

  fsg_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_array (
    .clk(clk), .rst(rst), .commit_prog(commit_prog), .prog_addr(prog_addr),
    .prog_data(prog_data), .commit_erase(commit_erase), .erase_mask(erase_mask),
    .rd_addr(rd_addr), .cur_addr(op_addr), .rd_byte(rd_byte), .cur_byte(cur_byte)
  );

  fsg_rdmux #(.SECT_W(SECT_W)) u_rdmux (
    .clk(clk), .rst(rst), .flash_reset(flash_reset), .op_begin(op_begin),
    .rd_req(rd_req), .rd_sect(rd_addr[ADDR_W-1 -: SECT_W]), .rd_byte(rd_byte),
    .hit_mask(hit_mask), .poll_bit(poll_bit), .err(err), .win_open(win_open),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: tb/flash_status_gen_bench.sv
module flash_status_gen_bench;
  localparam int AW = 6;
  localparam int SW = 2;
  localparam int WIN = 20;
  localparam int PP = 10;

  logic clk = 1'b0;
  logic rst, op_start, tmr_done, tmr_fail, flash_reset, rd_req, rd_valid;
  logic [1:0] op_kind;
  logic [AW-1:0] op_addr, rd_addr;
  logic [7:0] op_data, rd_data;
  logic [3:0] prot_mask;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  flash_status_gen #(.ADDR_W(AW), .SECT_W(SW), .ERASE_WIN_CYC(WIN), .PROT_BUSY_CYC(PP))
  u_flash_status_gen (
    .clk(clk), .rst(rst), .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr),
    .op_data(op_data), .prot_mask(prot_mask), .tmr_done(tmr_done), .tmr_fail(tmr_fail),
    .flash_reset(flash_reset), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // monitor: pops expected items as responses appear
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R12 unexpected response actual=%h expected=none", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", t, rd_data, e);
        end
      end
    end
  end

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk); rd_req = 1'b1; rd_addr = a;
    @(negedge clk); rd_req = 1'b0;
  endtask

  task automatic op(input logic [1:0] k, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); op_start = 1'b1; op_kind = k; op_addr = a; op_data = d;
    @(negedge clk); op_start = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); tmr_done = 1'b1;
    @(negedge clk); tmr_done = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; op_start = 0; op_kind = 0; op_addr = 0; op_data = 0; prot_mask = 0;
    tmr_done = 0; tmr_fail = 0; flash_reset = 0; rd_req = 0; rd_addr = 0;
    idle(3);
    checks++;
    if (rd_valid !== 1'b0) begin
      errors++;
      $display("FAIL R11 rd_valid actual=%b expected=0", rd_valid);
    end
    rst = 1'b0;
    rd(6'h05, 8'hFF, "R11 erased after reset");

    // setup bytes in sectors 1,2,3
    op(2'd0, 6'h15, 8'h0F); done_pulse(); rd(6'h15, 8'h0F, "R1 program result");
    op(2'd0, 6'h35, 8'h55); done_pulse(); rd(6'h35, 8'h55, "R1 program result");
    op(2'd0, 6'h25, 8'h12); done_pulse(); rd(6'h25, 8'h12, "R1 program result");

    // R1/R3/R4 program polling and toggling
    op(2'd0, 6'h05, 8'h3C);
    rd(6'h05, 8'h88, "R1 inverted bit7, R3 first toggle 0");
    rd(6'h05, 8'hC8, "R3 toggle flips");
    rd(6'h25, 8'h12, "R4 other sector returns data");
    rd(6'h05, 8'h88, "R3 toggle flips back");
    done_pulse();
    rd(6'h05, 8'h3C, "R1 true value after done");
    rd(6'h05, 8'h3C, "R3 stable after done");

    // R7 zero-to-one program error
    op(2'd0, 6'h05, 8'h7C);
    rd(6'h05, 8'hA8, "R7 error bit set");
    done_pulse();
    rd(6'h05, 8'hE8, "R7 done ignored while error");
    @(negedge clk); flash_reset = 1'b1; @(negedge clk); flash_reset = 1'b0;
    rd(6'h05, 8'h3C, "R8 reset-flash clears, R7 array unchanged");

    // R5 protected program
    prot_mask = 4'b0010;
    op(2'd0, 6'h15, 8'h00);
    rd(6'h15, 8'h0F, "R5 protected program ignored");
    rd(6'h15, 8'h0F, "R5 protected program no toggle");

    // R2/R9 sector erase accumulation
    op(2'd1, 6'h00, 8'h00);
    rd(6'h05, 8'h00, "R2 erase bit7 0, R9 window open");
    rd(6'h05, 8'h40, "R3 erase toggle");
    idle(10);
    op(2'd1, 6'h20, 8'h00);
    done_pulse();
    rd(6'h25, 8'h00, "R9 added sector, window restarted");
    rd(6'h05, 8'h40, "R9 done ignored in window");
    rd(6'h35, 8'h55, "R4 unselected sector data");
    idle(WIN + 5);
    rd(6'h05, 8'h08, "R9 window expired bit3 1");
    done_pulse();
    rd(6'h05, 8'hFF, "R2 sector 0 erased");
    rd(6'h25, 8'hFF, "R2 sector 2 erased");
    rd(6'h15, 8'h0F, "R10 protected sector kept");

    // R6 bulk erase, all protected
    prot_mask = 4'hF;
    op(2'd2, 6'h30, 8'h00);
    rd(6'h35, 8'h08, "R6 protect pulse status");
    rd(6'h35, 8'h48, "R6 protect pulse toggle");
    idle(PP + 3);
    rd(6'h35, 8'h55, "R6 nothing erased");

    // R8 timer failure
    prot_mask = 4'b0000;
    op(2'd0, 6'h06, 8'hA5);
    rd(6'h06, 8'h08, "R1 bit7 inverse of 1");
    @(negedge clk); tmr_fail = 1'b1; @(negedge clk); tmr_fail = 1'b0;
    rd(6'h06, 8'h68, "R8 failure sets bit5");
    done_pulse();
    rd(6'h06, 8'h28, "R8 error sticky");
    @(negedge clk); flash_reset = 1'b1; @(negedge clk); flash_reset = 1'b0;
    rd(6'h06, 8'hFF, "R8 aborted after reset-flash");

    // R10 bulk erase with sector 1 protected
    prot_mask = 4'b0010;
    op(2'd2, 6'h00, 8'h00);
    op(2'd1, 6'h10, 8'h00);
    rd(6'h35, 8'h08, "R10 bulk status, start while busy ignored");
    rd(6'h15, 8'h0F, "R10 protected sector not targeted");
    done_pulse();
    rd(6'h35, 8'hFF, "R10 unprotected erased");
    rd(6'h15, 8'h0F, "R10 protected kept");

    idle(4);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R12 missing responses actual=%0d expected=0", exp_q.size());
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule